// File: doc/BRIEF.md
# Illegal Opcode Trap Injector

This block sits on the read path between the memory-side data bus and the data pins of an 8-bit processor that uses the 6502 instruction encoding. On each cycle it looks at three things: the byte coming from memory, the processor's opcode-fetch strobe and the read strobe. When all three show an opcode fetch of a byte that the processor does not implement, the block turns off the normal transceiver path. In the same cycle it drives the break opcode 0x00 onto the processor side. The processor then takes its break vector at 0xFFFE/0xFFFF, and handler software can look into the fault.

Only reads that happen while the fetch strobe is high are candidates for substitution. Operand bytes and data transfers go through untouched, even when their values match an unimplemented opcode.

On the clock edge that ends a substituted fetch, the block registers two things: a one-cycle trap pulse and a copy of the original byte. Together they let the handler tell a real break instruction apart from a trapped one.

The legality table has 256 entries. It is computed at elaboration from the documented opcode set. A parameter mask can mark further opcodes as trapped. While reset is held, every entry reads as valid.

Top module: `otrap_injector`

## Requirements
- R1: When `sync_i`, `rd_i` and the table flag for `mem_data_i` are all 1 in a cycle, that same cycle shows `cpu_data_o` = 0x00, `force_en_o` = 1 and `xcvr_en_o` = 0.
- R2: A fetch (`sync_i`=1, `rd_i`=1) of an implemented opcode drives `cpu_data_o` = `mem_data_i`, `xcvr_en_o` = 1 and `force_en_o` = 0.
- R3: When `sync_i` is 0, no substitution occurs for any byte value, including unimplemented opcode values (operand and data cycles).
- R4: When `rd_i` is 0, no substitution occurs, even if `sync_i` is 1 and the byte is unimplemented.
- R5: In every cycle exactly one of `xcvr_en_o` and `force_en_o` is 1.
- R6: `trap_o` is 1 in the cycle that follows a substituted fetch and 0 in the cycle that follows any other cycle.
- R7: `trap_byte_o` loads the original `mem_data_i` at the edge that ends a substituted fetch and holds it until the next substituted fetch.
- R8: A fetch of a real 0x00 opcode passes through unchanged and does not raise `trap_o`.
- R9: While `rst_i` is 1 no substitution occurs. After a reset edge, `trap_o` = 0 and `trap_byte_o` = 0x00.
- R10: With default parameters the table follows the documented NMOS opcode set. For example, 0x02, 0x03, 0x04, 0x1A, 0x80, 0x89, 0x9E and 0xFF are trapped, while 0x00, 0x24, 0x4C, 0x60, 0x96, 0x9A, 0xA9, 0xBE and 0xEA are not.
- R11: Setting bit n of parameter `EXTRA_TRAPS` also traps opcode n, for example 0xEA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus cycle per period |
| rst_i | input | 1 | Synchronous active-high reset |
| mem_data_i | input | 8 | Byte read from the memory-side bus |
| sync_i | input | 1 | Opcode-fetch strobe from the processor |
| rd_i | input | 1 | Read strobe, 1 when the processor reads |
| cpu_data_o | output | 8 | Byte presented to the processor data pins |
| xcvr_en_o | output | 1 | Enable of the normal bus transceiver path |
| force_en_o | output | 1 | Enable of the forced-zero driver |
| trap_o | output | 1 | One-cycle pulse after a substituted fetch |
| trap_byte_o | output | 8 | Original byte of the last substituted fetch |

## Verification
The assertions assume that `sync_i`, `rd_i` and `mem_data_i` are stable and known for the whole of a clock period. They also assume that `rst_i` is held high from time zero until the first edges have passed. The bench meets this by changing inputs only on the falling edge and starting in reset. It mixes fetches of legal and illegal opcodes with operand and write cycles that carry illegal byte values, so every gating term of the substitution is exercised from both sides.

// File: rtl/otrap_pkg.sv
package otrap_pkg;

    localparam int BYTE_W    = 8;
    localparam int TABLE_N   = 1 << BYTE_W;
    localparam logic [BYTE_W-1:0] BRK_CODE = 8'h00;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t data;
        logic  fetch;
        logic  read;
    } bus_in_t;

    typedef enum logic [1:0] {
        PATH_IDLE  = 2'b00,
        PATH_XCVR  = 2'b01,
        PATH_FORCE = 2'b10
    } path_e;

    // Documented NMOS opcode set, decoded from the aaabbbcc fields.
    function automatic logic op_is_documented(input byte_t op);
        logic [2:0] aaa;
        logic [2:0] bbb;
        logic [1:0] cc;
        logic       ok;
        aaa = op[7:5];
        bbb = op[4:2];
        cc  = op[1:0];
        ok  = 1'b0;
        case (cc)
            2'd1: ok = (op != 8'h89);
            2'd2: begin
                case (bbb)
                    3'd0: ok = (aaa == 3'd5);
                    3'd1, 3'd2, 3'd3, 3'd5: ok = 1'b1;
                    3'd4: ok = 1'b0;
                    3'd6: ok = (aaa == 3'd4) || (aaa == 3'd5);
                    3'd7: ok = (aaa != 3'd4);
                    default: ok = 1'b0;
                endcase
            end
            2'd0: begin
                case (bbb)
                    3'd0: ok = (aaa != 3'd4);
                    3'd1: ok = (aaa == 3'd1) || (aaa >= 3'd4);
                    3'd2, 3'd4, 3'd6: ok = 1'b1;
                    3'd3: ok = (aaa != 3'd0);
                    3'd5: ok = (aaa == 3'd4) || (aaa == 3'd5);
                    3'd7: ok = (aaa == 3'd5);
                    default: ok = 1'b0;
                endcase
            end
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic path_e pick_path(input logic substitute);
        return substitute ? PATH_FORCE : PATH_XCVR;
    endfunction

endpackage

// File: rtl/otrap_lookup.sv
module otrap_lookup
    import otrap_pkg::*;
#(
    parameter logic [TABLE_N-1:0] EXTRA_TRAPS = '0
) (
    input  logic  rst_i,
    input  byte_t index_i,
    output logic  illegal_o
);
    logic [TABLE_N-1:0] table_q;

    for (genvar g = 0; g < TABLE_N; g++) begin : g_entry
        localparam logic BAD = !op_is_documented(byte_t'(g)) || EXTRA_TRAPS[g];
        assign table_q[g] = BAD;
    end

    // All entries read valid while reset is held.
    always_comb begin
        illegal_o = rst_i ? 1'b0 : table_q[index_i];
    end

endmodule

// File: rtl/otrap_steer.sv
module otrap_steer
    import otrap_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  bus_in_t bus_i,
    input  logic    illegal_i,
    output byte_t   cpu_data_o,
    output logic    xcvr_en_o,
    output logic    force_en_o,
    output logic    subst_o
);
    path_e path;

    always_comb begin
        path       = pick_path(bus_i.fetch && bus_i.read && illegal_i);
        subst_o    = (path == PATH_FORCE);
        force_en_o = (path == PATH_FORCE);
        xcvr_en_o  = (path == PATH_XCVR);
        cpu_data_o = (path == PATH_FORCE) ? BRK_CODE : bus_i.data;
    end

    // R5
    one_driver_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({xcvr_en_o, force_en_o}) == 1);

    // R1
    forced_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        force_en_o |-> (cpu_data_o == 8'h00) && illegal_i);

    // R2
    pass_through_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        xcvr_en_o |-> cpu_data_o == bus_i.data);

endmodule

// File: rtl/otrap_capture.sv
module otrap_capture
    import otrap_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  bus_in_t bus_i,
    input  logic    subst_i,
    output logic    trap_o,
    output byte_t   trap_byte_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            trap_o      <= 1'b0;
            trap_byte_o <= '0;
        end else begin
            trap_o <= subst_i;
            if (subst_i) begin
                trap_byte_o <= bus_i.data;
            end
        end
    end

    // R3
    fetch_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_i.fetch |-> !subst_i);

    // R4
    read_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_i.read |-> !subst_i);

    // R6
    pulse_follows_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        subst_i |=> trap_o);

    // R7
    byte_kept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !subst_i |=> $stable(trap_byte_o));

    // R8
    real_brk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_i.fetch && bus_i.read && bus_i.data == BRK_CODE) |=> !trap_o);

endmodule

// File: rtl/otrap_injector.sv
module otrap_injector
    import otrap_pkg::*;
#(
    parameter logic [255:0] EXTRA_TRAPS = '0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [7:0] mem_data_i,
    input  logic       sync_i,
    input  logic       rd_i,
    output logic [7:0] cpu_data_o,
    output logic       xcvr_en_o,
    output logic       force_en_o,
    output logic       trap_o,
    output logic [7:0] trap_byte_o
);
    bus_in_t bus;
    logic    illegal;
    logic    subst;

    assign bus = '{data: mem_data_i, fetch: sync_i, read: rd_i};

    otrap_lookup #(.EXTRA_TRAPS(EXTRA_TRAPS)) lookup_i (
        .rst_i     (rst_i),
        .index_i   (mem_data_i),
        .illegal_o (illegal)
    );

    otrap_steer steer_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bus_i      (bus),
        .illegal_i  (illegal),
        .cpu_data_o (cpu_data_o),
        .xcvr_en_o  (xcvr_en_o),
        .force_en_o (force_en_o),
        .subst_o    (subst)
    );

    otrap_capture capture_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bus_i       (bus),
        .subst_i     (subst),
        .trap_o      (trap_o),
        .trap_byte_o (trap_byte_o)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> !trap_o && trap_byte_o == 8'h00);

endmodule

// File: tb/otrap_injector_tb_top.sv
module otrap_injector_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_data = 8'h00;
    logic       sync = 1'b0;
    logic       rd = 1'b0;

    logic [7:0] cpu_data, cpu_data_x;
    logic       xcvr_en, xcvr_en_x;
    logic       force_en, force_en_x;
    logic       trap, trap_x;
    logic [7:0] trap_byte, trap_byte_x;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_trap = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    otrap_injector dut_i (
        .clk_i(clk), .rst_i(rst), .mem_data_i(mem_data), .sync_i(sync), .rd_i(rd),
        .cpu_data_o(cpu_data), .xcvr_en_o(xcvr_en), .force_en_o(force_en),
        .trap_o(trap), .trap_byte_o(trap_byte)
    );

    otrap_injector #(.EXTRA_TRAPS(256'd1 << 8'hEA)) dut_x (
        .clk_i(clk), .rst_i(rst), .mem_data_i(mem_data), .sync_i(sync), .rd_i(rd),
        .cpu_data_o(cpu_data_x), .xcvr_en_o(xcvr_en_x), .force_en_o(force_en_x),
        .trap_o(trap_x), .trap_byte_o(trap_byte_x)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge, check combinational outputs,
    // then check the registered trap outputs at the next falling edge.
    task automatic bus_cycle(input string req, input logic [7:0] b, input logic s,
                             input logic r, input logic exp_sub);
        mem_data = b;
        sync = s;
        rd = r;
        #1;
        check({req, " data"}, cpu_data, exp_sub ? 8'h00 : b);
        check({req, " force"}, force_en, exp_sub);
        check({req, " xcvr"}, xcvr_en, !exp_sub);
        @(negedge clk);
        if (exp_sub) last_trap = b;
        check({req, " pulse"}, trap, exp_sub);
        check({req, " byte"}, trap_byte, last_trap);
    endtask

    task automatic t_reset;
        // R9: inputs form an illegal fetch during reset
        mem_data = 8'h02; sync = 1'b1; rd = 1'b1;
        #1;
        check("R9 no subst in reset", force_en, 1'b0);
        check("R9 data in reset", cpu_data, 8'h02);
        @(negedge clk);
        check("R9 trap after reset edge", trap, 1'b0);
        check("R9 byte after reset edge", trap_byte, 8'h00);
        rst = 1'b0;
        sync = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_legal_fetches;
        logic [7:0] ok_list [9] = '{8'h24, 8'h4C, 8'h60, 8'h96, 8'h9A, 8'hA9, 8'hBE, 8'hEA, 8'hA2};
        foreach (ok_list[i]) bus_cycle("R2/R10 legal", ok_list[i], 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_illegal_fetches;
        logic [7:0] bad_list [8] = '{8'h02, 8'h03, 8'h04, 8'h1A, 8'h80, 8'h89, 8'h9E, 8'hFF};
        foreach (bad_list[i]) begin
            bus_cycle("R1/R10 illegal", bad_list[i], 1'b1, 1'b1, 1'b1);
            bus_cycle("R6 pulse drop", 8'h05, 1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic t_operands;
        // R3: operand/data cycles carrying illegal values
        bus_cycle("R3 operand", 8'h02, 1'b0, 1'b1, 1'b0);
        bus_cycle("R3 operand", 8'hFF, 1'b0, 1'b1, 1'b0);
        bus_cycle("R3 data", 8'h89, 1'b0, 1'b0, 1'b0);
        // R4: fetch strobe high but no read
        bus_cycle("R4 no read", 8'h03, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_real_brk;
        bus_cycle("R8 real brk", 8'h00, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_capture_hold;
        bus_cycle("R7 load", 8'h3B, 1'b1, 1'b1, 1'b1);
        bus_cycle("R7 hold operand", 8'h12, 1'b0, 1'b1, 1'b0);
        bus_cycle("R7 hold legal", 8'hA9, 1'b1, 1'b1, 1'b0);
        bus_cycle("R7 reload", 8'hDA, 1'b1, 1'b1, 1'b1);
        // back-to-back substituted fetches: pulse stays high each cycle
        bus_cycle("R6 back to back", 8'h7F, 1'b1, 1'b1, 1'b1);
        bus_cycle("R6 idle", 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mix_program;
        // opcode, operand, operand, opcode... with operands matching illegal codes
        bus_cycle("R2 mix op", 8'h4C, 1'b1, 1'b1, 1'b0);
        bus_cycle("R3 mix lo", 8'h0B, 1'b0, 1'b1, 1'b0);
        bus_cycle("R3 mix hi", 8'hF2, 1'b0, 1'b1, 1'b0);
        bus_cycle("R1 mix op", 8'hB3, 1'b1, 1'b1, 1'b1);
        bus_cycle("R3 mix wr", 8'h32, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_extra_mask;
        // R11: NOP 0xEA is trapped only in the instance with the extra mask
        mem_data = 8'hEA; sync = 1'b1; rd = 1'b1;
        #1;
        check("R11 extra data", cpu_data_x, 8'h00);
        check("R11 extra force", force_en_x, 1'b1);
        check("R11 extra xcvr", xcvr_en_x, 1'b0);
        check("R11 default untouched", cpu_data, 8'hEA);
        @(negedge clk);
        check("R11 extra pulse", trap_x, 1'b1);
        check("R11 extra byte", trap_byte_x, 8'hEA);
        sync = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_legal_fetches();
        t_illegal_fetches();
        t_operands();
        t_real_brk();
        t_capture_hold();
        t_mix_program();
        t_extra_mask();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule